// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 22-bit virtual address into a 16-bit physical address by walking a two-level page table kept in byte-addressed memory. The requester presents the virtual address together with a write flag and a user-mode flag. A base page number, held by software outside the block, names the page that holds the top-level table. The walker reads each 16-bit table entry as two single-byte reads. It checks the entry, steps down a level or stops, and finally returns either a physical address or a fault code.

On a successful translation the walker marks the leaf entry as used, and as dirty for a write, by writing back the entry's low byte. It skips that write when the byte would not change. The memory side carries one byte transfer at a time and may insert any number of wait cycles. The request side uses a four-phase handshake: the requester holds its request until done appears, then releases it.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits, from most to least significant, into a 7-bit top index (bits 21:15), a 7-bit leaf index (bits 14:8) and an 8-bit offset (bits 7:0). A successful translation reports res_fault = 00 and res_paddr = {leaf entry bits 15:8, offset}.
- R2: The top-level entry lies at byte address {pt_base, top index, 0}. Its high byte (bits 15:8) is read from that even address first, then its low byte from the next address.
- R3: When the top-level entry passes its checks, the leaf entry is read the same way from {top entry bits 15:8, leaf index, 0}, high byte first.
- R4: An entry with bit 0 (valid) clear, at either level, ends the walk with res_fault = 01 and res_paddr = 0, and no further memory access follows. The valid check comes before the permission checks.
- R5: A present entry at either level refuses access when a write meets bit 1 (write-allowed) clear, or when a user-mode request meets bit 7 (kernel-only) set. The walk then ends with res_fault = 10 and res_paddr = 0.
- R6: After a successful leaf read, the new low byte is the old one with bit 2 (use) set and, for a write, bit 3 (dirty) set. It is written to the leaf entry's odd address only if it differs from the old byte. A faulting walk performs no write.
- R7: done rises after the walk. It stays high with res_paddr and res_fault stable while req_valid is high, drops in the cycle after req_valid is seen low, and no new request is taken while done is high.
- R8: A memory transfer holds mem_valid, mem_addr, mem_write and mem_wdata steady until mem_ready is sampled high. Wait cycles of any length change no result.
- R9: During and just after reset, done and mem_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 8 | Page number of the top-level table, sampled when a request is taken |
| req_valid | input | 1 | Request present; held until done is seen |
| req_vaddr | input | 22 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| done | output | 1 | Result valid |
| res_paddr | output | 16 | Physical address (0 on a fault) |
| res_fault | output | 2 | 00 ok, 01 invalid page, 10 access violation |
| mem_valid | output | 1 | Byte transfer requested |
| mem_write | output | 1 | 1 = byte write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid while mem_ready is high |
| mem_ready | input | 1 | Transfer completes this cycle |

## Verification
Random table contents and addresses are mixed with directed cases. The directed cases separate a fault at the top level from one at the leaf, an invalid page from an access violation, and a write from a user-mode refusal, including an entry that is both invalid and kernel-only. Leaf bytes with the use and dirty bits already set show whether the write-back is skipped correctly. Runs without wait cycles are compared with runs under random stalls, so that the outcome is shown not to depend on memory timing. Holding the request for several cycles after done shows whether the result stays steady.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PW = 8,
  parameter int IW = 7,
  parameter int OW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PW-1:0]       pt_base,
  input  logic                req_valid,
  input  logic [2*IW+OW-1:0]  req_vaddr,
  input  logic                req_write,
  input  logic                req_user,
  output logic                done,
  output logic [PW+OW-1:0]    res_paddr,
  output logic [1:0]          res_fault,
  output logic                mem_valid,
  output logic                mem_write,
  output logic [PW+OW-1:0]    mem_addr,
  output logic [7:0]          mem_wdata,
  input  logic [7:0]          mem_rdata,
  input  logic                mem_ready
);
  localparam int VW = 2*IW + OW;
  localparam int B_VAL = 0, B_WR = 1, B_USE = 2, B_DRT = 3, B_KRN = 7;
  localparam logic [1:0] F_OK = 2'b00, F_INV = 2'b01, F_ACC = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_AHI, S_ALO, S_BHI, S_BLO, S_WB, S_DONE} st_t;

  st_t         st;
  logic [VW-1:0] va;
  logic        wr, usr;
  logic [PW-1:0] pg, hib;
  logic [7:0]  newlo;

  wire xfer    = mem_valid & mem_ready;
  wire leaf    = (st == S_BHI) | (st == S_BLO) | (st == S_WB);
  wire lowhalf = (st == S_ALO) | (st == S_BLO) | (st == S_WB);
  wire [IW-1:0] idx = leaf ? va[OW +: IW] : va[OW+IW +: IW];

  assign mem_addr  = {pg, idx, lowhalf};
  assign mem_valid = (st != S_IDLE) & (st != S_DONE);
  assign mem_write = (st == S_WB);
  assign mem_wdata = newlo;
  assign done      = (st == S_DONE);

  wire bad_v = ~mem_rdata[B_VAL];
  wire deny  = (wr & ~mem_rdata[B_WR]) | (usr & mem_rdata[B_KRN]);
  wire [7:0] upd = mem_rdata | (8'b1 << B_USE) | (wr ? (8'b1 << B_DRT) : 8'b0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va        <= '0;
      wr        <= 1'b0;
      usr       <= 1'b0;
      pg        <= '0;
      hib       <= '0;
      newlo     <= '0;
      res_paddr <= '0;
      res_fault <= F_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va  <= req_vaddr;
          wr  <= req_write;
          usr <= req_user;
          pg  <= pt_base;
          st  <= S_AHI;
        end
        S_AHI: if (xfer) begin
          hib <= mem_rdata;
          st  <= S_ALO;
        end
        S_ALO: if (xfer) begin
          if (bad_v || deny) begin
            res_fault <= bad_v ? F_INV : F_ACC;
            res_paddr <= '0;
            st        <= S_DONE;
          end else begin
            pg <= hib;
            st <= S_BHI;
          end
        end
        S_BHI: if (xfer) begin
          hib <= mem_rdata;
          st  <= S_BLO;
        end
        S_BLO: if (xfer) begin
          if (bad_v || deny) begin
            res_fault <= bad_v ? F_INV : F_ACC;
            res_paddr <= '0;
            st        <= S_DONE;
          end else begin
            res_fault <= F_OK;
            res_paddr <= {hib, va[OW-1:0]};
            newlo     <= upd;
            st        <= (upd != mem_rdata) ? S_WB : S_DONE;
          end
        end
        S_WB: if (xfer) st <= S_DONE;
        S_DONE: if (!req_valid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        done,
  input logic [15:0] res_paddr,
  input logic [1:0]  res_fault,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_ready
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && req_valid |=> done && $stable(res_paddr) && $stable(res_fault)); // R7
  AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    done && !req_valid |=> !done); // R7
  AST_QUIET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid); // R7
  AST_WB_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> mem_addr[0] && mem_wdata[2]); // R6
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_fault != 2'b11 && (res_fault == 2'b00 || res_paddr == 16'h0)); // R4
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .done(done),
  .res_paddr(res_paddr), .res_fault(res_fault), .mem_valid(mem_valid),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pt_base = '0;
  logic req_valid = 1'b0;
  logic [21:0] req_vaddr = '0;
  logic req_write = 1'b0, req_user = 1'b0;
  logic done;
  logic [15:0] res_paddr;
  logic [1:0] res_fault;
  logic mem_valid, mem_write;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .done(done), .res_paddr(res_paddr), .res_fault(res_fault),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int total = 0, bad = 0;
  int wait_mode = 0;
  logic [7:0] mem [int];
  int rlog [0:7];
  int rn = 0, wn = 0, wa = 0, wd = 0;

  function automatic logic [7:0] rdb(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic put(int a, logic [15:0] e);
    mem[a] = e[15:8];
    mem[a+1] = e[7:0];
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_valid && rst_n) begin
      if (wait_mode == 0 || $urandom_range(0, 2) == 0) begin
        mem_ready = 1'b1;
        if (mem_write) begin
          wn++; wa = int'(mem_addr); wd = int'(mem_wdata);
          mem[int'(mem_addr)] = mem_wdata;
        end else begin
          mem_rdata = rdb(int'(mem_addr));
          if (rn < 8) rlog[rn] = int'(mem_addr);
          rn++;
        end
      end else mem_ready = 1'b0;
    end else mem_ready = 1'b0;
  end

  task automatic run(logic [21:0] va, logic w, logic u, logic [7:0] base, string tag);
    int en, ea [0:3], ef, epa, ew, ewa, ewd, cnt;
    logic [15:0] e1, e2;
    logic [7:0] nl;
    logic [15:0] hp;
    logic [1:0] hf;
    en = 0; ef = 0; epa = 0; ew = 0; ewa = 0; ewd = 0;
    ea[0] = {base, va[21:15], 1'b0}; ea[1] = ea[0] + 1;
    e1 = {rdb(ea[0]), rdb(ea[1])}; en = 2;
    if (!e1[0]) ef = 1;
    else if ((w && !e1[1]) || (u && e1[7])) ef = 2;
    else begin
      ea[2] = {e1[15:8], va[14:8], 1'b0}; ea[3] = ea[2] + 1;
      e2 = {rdb(ea[2]), rdb(ea[3])}; en = 4;
      if (!e2[0]) ef = 1;
      else if ((w && !e2[1]) || (u && e2[7])) ef = 2;
      else begin
        epa = {e2[15:8], va[7:0]};
        nl = e2[7:0] | 8'h04 | (w ? 8'h08 : 8'h00);
        if (nl != e2[7:0]) begin ew = 1; ewa = ea[3]; ewd = nl; end
      end
    end
    rn = 0; wn = 0;
    @(negedge clk);
    pt_base = base; req_vaddr = va; req_write = w; req_user = u; req_valid = 1'b1;
    cnt = 0;
    while (!done && cnt < 2000) begin @(negedge clk); cnt++; end
    chk({tag, " R7 done reached"}, int'(done), 1);
    chk({tag, " R1 R4 R5 fault code"}, int'(res_fault), ef);
    chk({tag, " R1 physical address"}, int'(res_paddr), epa);
    chk({tag, " R2 R3 R4 read count"}, rn, en);
    for (int i = 0; i < en && i < rn; i++)
      chk({tag, (i < 2) ? " R2 top entry address" : " R3 leaf entry address"}, rlog[i], ea[i]);
    chk({tag, " R6 write-back count"}, wn, ew);
    if (ew == 1 && wn == 1) begin
      chk({tag, " R6 write-back address"}, wa, ewa);
      chk({tag, " R6 write-back data"}, wd, ewd);
    end
    hp = res_paddr; hf = res_fault;
    for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
      @(negedge clk);
      chk({tag, " R7 done held"}, int'(done), 1);
      chk({tag, " R7 result stable"}, int'({hf, hp}), int'({res_fault, res_paddr}));
      chk({tag, " R7 no memory access while done"}, int'(mem_valid), 0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R7 done drops"}, int'(done), 0);
  endtask

  initial begin
    logic [21:0] va;
    logic [7:0] base;
    void'($urandom(32'd20071203));
    repeat (3) @(negedge clk);
    chk("R9 done in reset", int'(done), 0);
    chk("R9 mem_valid in reset", int'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 done after reset", int'(done), 0);
    chk("R9 mem_valid after reset", int'(mem_valid), 0);

    va = {7'd3, 7'd5, 8'hA7};
    for (int m = 0; m < 2; m++) begin
      wait_mode = m;
      put(16'h1006, 16'h2201); put(16'h220A, 16'h5501);
      run(va, 0, 0, 8'h10, "read ok");
      chk("R1 directed address", int'(res_paddr), 16'h55A7);
      put(16'h220A, 16'h5505);
      run(va, 0, 0, 8'h10, "use already set");
      put(16'h1006, 16'h2203); put(16'h220A, 16'h5503);
      run(va, 1, 0, 8'h10, "write sets dirty");
      put(16'h220A, 16'h550F);
      run(va, 1, 0, 8'h10, "write no change");
      put(16'h1006, 16'h2200);
      run(va, 0, 0, 8'h10, "top invalid");
      put(16'h1006, 16'h2201); put(16'h220A, 16'h5500);
      run(va, 0, 0, 8'h10, "leaf invalid");
      put(16'h1006, 16'h2201); put(16'h220A, 16'h5503);
      run(va, 1, 0, 8'h10, "top read-only");
      put(16'h1006, 16'h2203); put(16'h220A, 16'h5583);
      run(va, 0, 1, 8'h10, "leaf kernel-only");
      chk("R5 directed violation", int'(res_fault), 2);
      put(16'h1006, 16'h2280);
      run(va, 0, 1, 8'h10, "invalid before kernel");
      chk("R4 directed priority", int'(res_fault), 1);
    end

    for (int t = 0; t < 300; t++) begin
      logic [7:0] f1, f2;
      logic [7:0] p1;
      int a1;
      wait_mode = int'($urandom_range(0, 1));
      base = 8'($urandom);
      va = 22'($urandom);
      p1 = 8'($urandom);
      f1 = 8'($urandom) & 8'hCF; if ($urandom_range(0, 4) != 0) f1[0] = 1'b1;
      f2 = 8'($urandom) & 8'hCF; if ($urandom_range(0, 4) != 0) f2[0] = 1'b1;
      a1 = {base, va[21:15], 1'b0};
      put(a1, {p1, f1});
      put({p1, va[14:8], 1'b0}, {8'($urandom), f2});
      run(va, 1'($urandom), 1'($urandom), base, "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    bad++; total++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule